// File: doc/BRIEF.md
# Audio Sample Transmit FIFO

This block buffers playback samples for a stereo or mono audio converter path. A processor or DMA engine writes samples through a small 32-bit register window. Each written sample is widened to a 24-bit converter word as it enters the buffer. The block exposes the buffered samples as a left/right pair, and it advances that pair once per output sample period on a strobe from the rate generator.

A DMA request output tells the DMA engine when to refill the buffer. The request rises while plenty of slots are free and falls when free space becomes short, with a hold band between the two levels. Software chooses the sample width, the widening rule, mono or stereo framing, and what the converter hears when the buffer runs dry. It can also empty the buffer at any time. A 3-bit sample-rate code is stored in the control register and passed on to the external rate generator.

Top module: `pcm_tx_fifo`

## Requirements
- R1: After reset, `leftOut`, `rightOut`, `dmaReq` and `rateCode` are 0, the control register reads 0, and the status register reads 0x8000_0040 (64 free, empty).
- R2: A write to the control register (offset 0x04) with bit 0 set empties the buffer in that cycle. Bit 0 always reads back as 0. The next sample written is the next sample popped.
- R3: With bit 5 clear, a write to the data port (offset 0x0c) stores `wdata[15:0]`. If bit 24 is set, its MSB is copied into the 8 low bits of the 24-bit word. If bit 24 is clear, those 8 bits are zero.
- R4: With bit 5 set, a data-port write stores `wdata[31:8]` unchanged, whatever bit 24 holds.
- R5: The buffer holds 64 samples. A data write while it is full is dropped: the status register stays at 0 free and the buffered order is unchanged.
- R6: While control bit 4 is clear, `dmaReq` is 0 from the next cycle on.
- R7: With bit 4 set, `dmaReq` is a register updated each cycle from the free count. It clears when free < 2 << bits[22:21]. Otherwise it sets when free > bits[13:8]. Otherwise it keeps its value.
- R8: In stereo (bit 6 clear), a `popStrobe` with at least two samples buffered removes two of them. On the next cycle the older one appears on `leftOut` and the newer one on `rightOut`.
- R9: In mono (bit 6 set), a `popStrobe` with at least one sample buffered removes one, and it appears on both outputs on the next cycle.
- R10: With bit 26 clear, a `popStrobe` that finds too few samples for one frame drives both outputs to 0 on the next cycle and removes nothing.
- R11: With bit 26 set, such an underrun pop leaves both outputs unchanged and removes nothing.
- R12: Bits 31:29 of the control register are stored, read back, and driven on `rateCode`.
- R13: Reads are combinational on `addr`. The control register (0x04) returns its stored fields. The status register (0x08) returns the free-slot count in bits 6:0 and an empty flag in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| popStrobe | input | 1 | One pulse per output sample period |
| leftOut | output | 24 | Left converter word |
| rightOut | output | 24 | Right converter word |
| dmaReq | output | 1 | DMA refill request |
| rateCode | output | 3 | Stored sample-rate code |

## Verification
A wrong pointer would show up at the first pop that follows. `leftOut`/`rightOut` would carry a sample out of order, or a stale one, one cycle after the strobe. A wrong occupancy count would show at once in the status free field, which is read combinationally. It would reach `dmaReq` one cycle later as a missed or early edge. The bench sweeps complete 64-sample fills in every widening mode, with underruns at one and zero samples, and walks the request through both thresholds and the band between them.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int OUT_W = 24;

  localparam logic [7:0] ADDR_CTRL = 8'h04;
  localparam logic [7:0] ADDR_STAT = 8'h08;
  localparam logic [7:0] ADDR_DATA = 8'h0c;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic             flush;
    logic             push;
    logic [OUT_W-1:0] pushWord;
    logic             popOne;
    logic             popTwo;
    logic             zeroOut;
  } fifoCmdT;
endpackage

// File: rtl/pcm_tx_ctrl.sv
module pcm_tx_ctrl
  import pcm_tx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             popStrobe,
  input  logic [CNT_W-1:0] fifoCount,
  output fifoCmdT          cmd,
  output logic             dmaReq,
  output logic [2:0]       rateCode,
  output logic             dmaEn,
  output logic             holdLast,
  output logic [CNT_W-1:0] clrThr
);
  logic [2:0] rateQ;
  logic       holdQ, msbRepQ, monoQ, wideQ, dmaEnQ;
  logic [1:0] clrCntQ;
  logic [5:0] trigQ;
  logic       ctrlWr, dataWr, fullNow, underrun;
  logic [CNT_W-1:0] freeCnt, needCnt;
  logic [31:0] ctrlWord, statWord;

  assign ctrlWr  = wrEn && (addr == ADDR_CTRL);
  assign dataWr  = wrEn && (addr == ADDR_DATA);
  assign freeCnt = CNT_W'(DEPTH) - fifoCount;
  assign fullNow = (fifoCount == CNT_W'(DEPTH));
  assign needCnt = monoQ ? CNT_W'(1) : CNT_W'(2);
  assign underrun = fifoCount < needCnt;
  assign clrThr  = CNT_W'(2) << clrCntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateQ <= '0; holdQ <= 1'b0; msbRepQ <= 1'b0; clrCntQ <= '0;
      trigQ <= '0; monoQ <= 1'b0; wideQ <= 1'b0; dmaEnQ <= 1'b0;
    end else if (ctrlWr) begin
      rateQ   <= wdata[31:29];
      holdQ   <= wdata[26];
      msbRepQ <= wdata[24];
      clrCntQ <= wdata[22:21];
      trigQ   <= wdata[13:8];
      monoQ   <= wdata[6];
      wideQ   <= wdata[5];
      dmaEnQ  <= wdata[4];
    end
  end

  function automatic logic [OUT_W-1:0] widen(logic [31:0] w, logic wide, logic rep);
    logic [OUT_W-1:0] r;
    if (wide) r = w[31:8];
    else if (rep) r = {w[15:0], {8{w[15]}}};
    else r = {w[15:0], 8'h00};
    return r;
  endfunction

  always_comb begin
    cmd          = '0;
    cmd.flush    = ctrlWr && wdata[0];
    cmd.push     = dataWr && !fullNow;
    cmd.pushWord = widen(wdata, wideQ, msbRepQ);
    if (popStrobe) begin
      if (!underrun) begin
        cmd.popOne = monoQ;
        cmd.popTwo = !monoQ;
      end else begin
        cmd.zeroOut = !holdQ;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dmaReq <= 1'b0;
    else if (!dmaEnQ) dmaReq <= 1'b0;
    else if (freeCnt < clrThr) dmaReq <= 1'b0;
    else if (freeCnt > CNT_W'(trigQ)) dmaReq <= 1'b1;
  end

  assign ctrlWord = {rateQ, 2'b00, holdQ, 1'b0, msbRepQ, 1'b0, clrCntQ,
                     7'b0, trigQ, 1'b0, monoQ, wideQ, dmaEnQ, 4'b0};

  always_comb begin
    statWord = '0;
    statWord[CNT_W-1:0] = freeCnt;
    statWord[31] = (fifoCount == '0);
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rdata = ctrlWord;
      ADDR_STAT: rdata = statWord;
      default:   rdata = '0;
    endcase
  end

  assign rateCode = rateQ;
  assign dmaEn    = dmaEnQ;
  assign holdLast = holdQ;
endmodule

// File: rtl/pcm_tx_datapath.sv
module pcm_tx_datapath
  import pcm_tx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCmdT          cmd,
  output logic [CNT_W-1:0] fifoCount,
  output logic [OUT_W-1:0] leftOut,
  output logic [OUT_W-1:0] rightOut
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [OUT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, rdNext;
  logic [1:0]       popN;

  assign rdNext = rdPtr + PTR_W'(1);
  assign popN   = cmd.popTwo ? 2'd2 : (cmd.popOne ? 2'd1 : 2'd0);

  always_ff @(posedge clk) begin
    if (cmd.push && !cmd.flush) mem[wrPtr] <= cmd.pushWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; fifoCount <= '0;
    end else if (cmd.flush) begin
      wrPtr <= '0; rdPtr <= '0; fifoCount <= '0;
    end else begin
      wrPtr     <= wrPtr + PTR_W'(cmd.push);
      rdPtr     <= rdPtr + PTR_W'(popN);
      fifoCount <= fifoCount + CNT_W'(cmd.push) - CNT_W'(popN);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftOut <= '0; rightOut <= '0;
    end else if (cmd.popOne) begin
      leftOut <= mem[rdPtr]; rightOut <= mem[rdPtr];
    end else if (cmd.popTwo) begin
      leftOut <= mem[rdPtr]; rightOut <= mem[rdNext];
    end else if (cmd.zeroOut) begin
      leftOut <= '0; rightOut <= '0;
    end
  end
endmodule

// File: rtl/pcm_tx_fifo.sv
module pcm_tx_fifo
  import pcm_tx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              popStrobe,
  output logic [OUT_W-1:0]  leftOut,
  output logic [OUT_W-1:0]  rightOut,
  output logic              dmaReq,
  output logic [2:0]        rateCode
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoCmdT          cmd;
  logic [CNT_W-1:0] fifoCount, clrThr;
  logic             dmaEn, holdLast, flushStb;

  assign flushStb = cmd.flush;

  pcm_tx_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .popStrobe(popStrobe), .fifoCount(fifoCount), .cmd(cmd),
    .dmaReq(dmaReq), .rateCode(rateCode), .dmaEn(dmaEn),
    .holdLast(holdLast), .clrThr(clrThr)
  );

  pcm_tx_datapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .fifoCount(fifoCount),
    .leftOut(leftOut), .rightOut(rightOut)
  );
endmodule

// File: rtl/pcm_tx_fifo_chk.sv
module pcm_tx_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] fifoCount,
  input logic [CNT_W-1:0] clrThr,
  input logic             dmaEn,
  input logic             holdLast,
  input logic             flushStb,
  input logic             popStrobe,
  input logic [23:0]      leftOut,
  input logic [23:0]      rightOut,
  input logic             dmaReq
);
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  p_flush_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    flushStb |=> (fifoCount == '0));

  p_dma_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEn |=> !dmaReq);

  p_dma_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (CNT_W'(DEPTH) - fifoCount < clrThr) |=> !dmaReq);

  p_under_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (popStrobe && fifoCount == '0 && !holdLast && !flushStb)
      |=> (leftOut == '0 && rightOut == '0));

  p_under_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (popStrobe && fifoCount == '0 && holdLast)
      |=> ($stable(leftOut) && $stable(rightOut)));
endmodule

bind pcm_tx_fifo pcm_tx_fifo_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .clrThr(clrThr),
  .dmaEn(dmaEn), .holdLast(holdLast), .flushStb(flushStb),
  .popStrobe(popStrobe), .leftOut(leftOut), .rightOut(rightOut),
  .dmaReq(dmaReq)
);

// File: tb/sim_pcm_tx_fifo.sv
module sim_pcm_tx_fifo;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = 8'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic popStrobe = 1'b0;
  logic [23:0] leftOut, rightOut;
  logic dmaReq;
  logic [2:0] rateCode;

  int errors = 0;
  int checks = 0;
  logic [31:0] rv;
  logic [23:0] ref_q [$];

  always #2 clk = ~clk;

  pcm_tx_fifo u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .popStrobe(popStrobe), .leftOut(leftOut),
    .rightOut(rightOut), .dmaReq(dmaReq), .rateCode(rateCode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pop();
    @(negedge clk); popStrobe = 1'b1;
    @(negedge clk); popStrobe = 1'b0;
  endtask

  function automatic logic [23:0] expand(input logic [31:0] d, input int mode);
    int v;
    if (mode == 2) return d[31:8];
    v = int'(d[15:0]);
    if (mode == 1) return 24'(v * 256 + ((v >= 32768) ? 255 : 0));
    return 24'(v * 256);
  endfunction

  function automatic logic [31:0] modeCtrl(input int mode);
    if (mode == 2) return 32'h0000_0021;
    if (mode == 1) return 32'h0100_0001;
    return 32'h0000_0001;
  endfunction

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] eL, eR;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h08, rv); chk("R1 status", rv, 32'h8000_0040);
    rd(8'h04, rv); chk("R1 ctrl", rv, 32'h0);
    chk("R1 left", {8'h0, leftOut}, 0);
    chk("R1 right", {8'h0, rightOut}, 0);
    chk("R1 dma", {31'b0, dmaReq}, 0);
    chk("R1 rate", {29'b0, rateCode}, 0);

    // R3 R4 R5 R8 sweep: full fill in each widening mode, stereo pops
    for (int m = 0; m < 3; m++) begin
      wr(8'h04, modeCtrl(m));
      ref_q.delete();
      for (int i = 0; i < 65; i++) begin
        d = 32'(i) * 32'h0102_0B37 + 32'(m) * 32'h0000_9E61 + 32'h00F0_8003;
        wr(8'h0c, d);
        if (i < 64) ref_q.push_back(expand(d, m));
        rd(8'h08, rv);
        chk("R5 free count", rv, (i < 63) ? 32'(63 - i) : 32'h0);
      end
      for (int p = 0; p < 32; p++) begin
        pop();
        eL = ref_q.pop_front(); eR = ref_q.pop_front();
        chk(m == 2 ? "R4 left" : "R3 R8 left", {8'h0, leftOut}, {8'h0, eL});
        chk(m == 2 ? "R4 right" : "R3 R8 right", {8'h0, rightOut}, {8'h0, eR});
      end
      rd(8'h08, rv); chk("R13 empty after drain", rv, 32'h8000_0040);
    end

    // R4 width ignores widening bit
    wr(8'h04, 32'h0100_0061);
    wr(8'h0c, 32'h1234_56FF);
    pop();
    chk("R4 R9 mono wide", {leftOut, rightOut[23:16]}, {24'h123456, 8'h12});
    chk("R9 mono right", {8'h0, rightOut}, 32'h0012_3456);

    // R9 mono ordering with MSB repeat
    wr(8'h04, 32'h0100_0041);
    wr(8'h0c, 32'h0000_9001); wr(8'h0c, 32'h0000_7002);
    pop(); chk("R9 mono first", {8'h0, leftOut}, 32'h0090_01FF);
    chk("R9 mono both", {8'h0, rightOut}, 32'h0090_01FF);
    pop(); chk("R9 mono second", {8'h0, rightOut}, 32'h0070_0200);

    // R2 flush mid-stream; readback of bit 0
    wr(8'h04, 32'h0000_0001);
    wr(8'h0c, 32'h0000_1111); wr(8'h0c, 32'h0000_2222); wr(8'h0c, 32'h0000_3333);
    wr(8'h04, 32'h0000_0001);
    rd(8'h08, rv); chk("R2 flush empties", rv, 32'h8000_0040);
    rd(8'h04, rv); chk("R2 flush bit reads 0", rv, 32'h0);
    wr(8'h0c, 32'h0000_AAAA); wr(8'h0c, 32'h0000_5555);
    pop();
    chk("R2 new left", {8'h0, leftOut}, 32'h00AA_AA00);
    chk("R2 new right", {8'h0, rightOut}, 32'h0055_5500);

    // R7 request thresholds: trig 40, clear count 3 (threshold 16)
    wr(8'h04, 32'h0060_2811);
    @(negedge clk);
    chk("R7 empty raises", {31'b0, dmaReq}, 1);
    for (int i = 0; i < 48; i++) wr(8'h0c, 32'(i));
    @(negedge clk);
    chk("R7 free 16 keeps", {31'b0, dmaReq}, 1);
    wr(8'h0c, 32'h0); @(negedge clk);
    chk("R7 free 15 drops", {31'b0, dmaReq}, 0);
    for (int i = 0; i < 5; i++) pop();
    @(negedge clk);
    chk("R7 free 25 holds low", {31'b0, dmaReq}, 0);
    for (int i = 0; i < 8; i++) pop();
    @(negedge clk);
    chk("R7 free 41 raises", {31'b0, dmaReq}, 1);
    for (int i = 0; i < 11; i++) wr(8'h0c, 32'(i));
    @(negedge clk);
    chk("R7 free 30 holds high", {31'b0, dmaReq}, 1);
    // R6 disable without flush
    wr(8'h04, 32'h0060_2800);
    @(negedge clk);
    chk("R6 disabled low", {31'b0, dmaReq}, 0);
    rd(8'h08, rv); chk("R6 R13 count kept", rv, 32'd30);

    // R10 underrun zeros, including one-sample stereo underrun
    wr(8'h04, 32'h0000_0001);
    wr(8'h0c, 32'h0000_4321); wr(8'h0c, 32'h0000_1234);
    pop();
    chk("R10 setup", {8'h0, leftOut}, 32'h0043_2100);
    wr(8'h0c, 32'h0000_7777);
    pop();
    chk("R10 zero left", {8'h0, leftOut}, 0);
    chk("R10 zero right", {8'h0, rightOut}, 0);
    rd(8'h08, rv); chk("R10 nothing removed", rv, 32'd63);

    // R11 hold last
    wr(8'h04, 32'h0400_0001);
    wr(8'h0c, 32'h0000_6543); wr(8'h0c, 32'h0000_0F0F);
    pop();
    pop();
    chk("R11 hold left", {8'h0, leftOut}, 32'h0065_4300);
    chk("R11 hold right", {8'h0, rightOut}, 32'h000F_0F00);
    wr(8'h0c, 32'h0000_0101);
    pop();
    chk("R11 one sample held", {8'h0, leftOut}, 32'h0065_4300);
    rd(8'h08, rv); chk("R11 nothing removed", rv, 32'd63);

    // R12 R13 rate code and control readback
    wr(8'h04, 32'hA540_2A50);
    rd(8'h04, rv); chk("R12 R13 ctrl readback", rv, 32'hA540_2A50);
    chk("R12 rate out", {29'b0, rateCode}, 32'd5);
    rd(8'h10, rv); chk("R13 unmapped reads 0", rv, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule